// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This unit makes exceptions precise in a five-stage in-order pipeline. Each cycle it looks at the exception sources that reach it. An arithmetic overflow is flagged by the execute stage. An undefined opcode and a system-service call are flagged by decode. External device interrupts and hardware-fault signals arrive with no fixed relation to any instruction. When it accepts an exception, the unit squashes the faulting instruction and every instruction behind it. Instructions further along the pipeline keep running and retire normally.

On acceptance, the flush strobes, the fetch redirect and the write-enable gate act in the same cycle, so the pipeline registers capture noop control bits on the next edge. The cause code and the faulting PC are captured into registers on that edge. The unit then takes no further exceptions until the handler acknowledges with a clear pulse.

An asynchronous request is charged to the instruction currently in decode. That instruction is squashed, and it is the one whose PC is saved.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After synchronous reset, `cause_o` = 0, `epc_o` = 0 and `held_o` = 0.
- R2: An execute-stage overflow outranks every decode-stage source. When one is accepted, the next cycle shows `cause_o` = 12 and `epc_o` = `ex_pc_i`.
- R3: With no overflow, decode-stage sources rank as follows: hardware fault (cause 15), then undefined instruction (cause 10), then service call (cause 8), then device interrupt (cause 0). The accepted one yields that cause, with `epc_o` = `id_pc_i`, on the next cycle.
- R4: `flush_o` acts in the same cycle as acceptance. Bit 0 empties the fetch/decode register, bit 1 the decode/execute register and bit 2 the execute/memory register. A decode-stage acceptance drives 3'b011, an overflow drives 3'b111, and any other cycle drives 3'b000.
- R5: On acceptance, `redirect_o` is 1 in the same cycle and `redirect_pc_o` carries the handler vector, 0x80000180 by default.
- R6: `ex_regwr_o` equals `ex_regwr_i`, except that it is 0 in a cycle where an overflow is accepted.
- R7: While `held_o` is 1, every source is ignored. `flush_o` stays 0, `redirect_o` stays 0, `ex_regwr_o` passes through, and `cause_o`/`epc_o` do not change.
- R8: A clear pulse while held drops `held_o` on the next cycle. A source raised in that same cycle is still ignored. A source in the following cycle is accepted.
- R9: `held_o` becomes 1 on the cycle after any acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_pc_i | input | 32 | PC of the instruction in decode |
| ex_pc_i | input | 32 | PC of the instruction in execute |
| id_undef_i | input | 1 | Decode found an undefined opcode |
| id_syscall_i | input | 1 | Decode found a service-call instruction |
| ex_ovf_i | input | 1 | Execute stage signed overflow |
| ex_regwr_i | input | 1 | Register write enable of the execute instruction |
| io_irq_i | input | 1 | External device interrupt request |
| hw_err_i | input | 1 | Hardware fault indication |
| ack_i | input | 1 | Handler clear of the held state |
| flush_o | output | 3 | Per-pipeline-register squash strobes |
| redirect_o | output | 1 | Force fetch PC this cycle |
| redirect_pc_o | output | 32 | Handler vector address |
| ex_regwr_o | output | 1 | Gated register write enable |
| cause_o | output | 5 | Recorded cause code |
| epc_o | output | 32 | Recorded faulting PC |
| held_o | output | 1 | Exception recorded, new ones masked |

## Verification
The hardest situation to reach from the ports is a clear pulse that lands in the same cycle as a fresh request. An overflow that collides with a decode-stage fault while the unit is still masked is equally hard to produce. Random traffic rarely lines these up. The stimulus therefore combines random source vectors with a high acknowledge rate, so mask transitions happen often. Directed cycles then raise every source at once, raise a request together with the clear, and raise one just after it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 5;
  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_IRQ = 5'd0,
    CAUSE_SVC = 5'd8,
    CAUSE_UND = 5'd10,
    CAUSE_OVF = 5'd12,
    CAUSE_HWF = 5'd15
  } cause_e;
  localparam logic [1:0] STG_DEC = 2'd1;
  localparam logic [1:0] STG_EXE = 2'd2;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                held_i,
  input  logic [XLEN-1:0]     id_pc_i,
  input  logic [XLEN-1:0]     ex_pc_i,
  input  logic                id_undef_i,
  input  logic                id_syscall_i,
  input  logic                ex_ovf_i,
  input  logic                io_irq_i,
  input  logic                hw_err_i,
  output logic                take_o,
  output logic [1:0]          src_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [XLEN-1:0]     pc_o
);
  logic any_dec;
  assign any_dec = hw_err_i | id_undef_i | id_syscall_i | io_irq_i;

  always_comb begin
    take_o  = 1'b0;
    src_o   = 2'd0;
    cause_o = CAUSE_IRQ;
    pc_o    = id_pc_i;
    if (!held_i) begin
      if (ex_ovf_i) begin
        take_o  = 1'b1;
        src_o   = STG_EXE;
        cause_o = CAUSE_OVF;
        pc_o    = ex_pc_i;
      end else if (any_dec) begin
        take_o = 1'b1;
        src_o  = STG_DEC;
        if (hw_err_i)          cause_o = CAUSE_HWF;
        else if (id_undef_i)   cause_o = CAUSE_UND;
        else if (id_syscall_i) cause_o = CAUSE_SVC;
        else                   cause_o = CAUSE_IRQ;
      end
    end
  end

  // R2: overflow always claims the execute PC
  a_r2_ovf_src: assert property (@(posedge clk) disable iff (rst)
    (ex_ovf_i && !held_i) |-> (src_o == STG_EXE && pc_o == ex_pc_i));
  // R7: masked state accepts nothing
  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    held_i |-> !take_o);
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NFLUSH = 3,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [1:0]        src_i,
  input  logic              ex_regwr_i,
  output logic [NFLUSH-1:0] flush_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              ex_regwr_o
);
  for (genvar g = 0; g < NFLUSH; g++) begin : g_flush
    localparam logic [1:0] IDX = g[1:0];
    assign flush_o[g] = take_i && (IDX <= src_i);
  end

  assign redirect_o    = take_i;
  assign redirect_pc_o = VECTOR;
  assign ex_regwr_o    = ex_regwr_i && !(take_i && src_i == STG_EXE);

  // R6: gated enable never asserts without the incoming one
  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    ex_regwr_o |-> ex_regwr_i);
  // R4: a squash of an older register implies the younger ones too
  a_r4_order: assert property (@(posedge clk) disable iff (rst)
    flush_o[NFLUSH-1] |-> flush_o[0]);
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               ack_i,
  output logic               held_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_o  <= 1'b0;
      cause_o <= '0;
      epc_o   <= '0;
    end else if (take_i) begin
      held_o  <= 1'b1;
      cause_o <= cause_i;
      epc_o   <= pc_i;
    end else if (ack_i) begin
      held_o  <= 1'b0;
    end
  end

  // R9: acceptance arms the mask
  a_r9_arm: assert property (@(posedge clk) disable iff (rst)
    take_i |=> held_o);
  // R8: clear releases the mask
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (held_o && ack_i) |=> !held_o);
  // R7: records frozen while masked
  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    held_o |=> ($stable(cause_o) && $stable(epc_o)));
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NFLUSH = 3,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    id_pc_i,
  input  logic [XLEN-1:0]    ex_pc_i,
  input  logic               id_undef_i,
  input  logic               id_syscall_i,
  input  logic               ex_ovf_i,
  input  logic               ex_regwr_i,
  input  logic               io_irq_i,
  input  logic               hw_err_i,
  input  logic               ack_i,
  output logic [NFLUSH-1:0]  flush_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               ex_regwr_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic               held_o
);
  logic               take;
  logic [1:0]         src;
  logic [CAUSE_W-1:0] cause_n;
  logic [XLEN-1:0]    pc_n;

  exc_arbiter #(.XLEN(XLEN)) arb_i (
    .clk(clk), .rst(rst), .held_i(held_o),
    .id_pc_i(id_pc_i), .ex_pc_i(ex_pc_i),
    .id_undef_i(id_undef_i), .id_syscall_i(id_syscall_i),
    .ex_ovf_i(ex_ovf_i), .io_irq_i(io_irq_i), .hw_err_i(hw_err_i),
    .take_o(take), .src_o(src), .cause_o(cause_n), .pc_o(pc_n)
  );

  exc_flush_ctrl #(.XLEN(XLEN), .NFLUSH(NFLUSH), .VECTOR(VECTOR)) fl_i (
    .clk(clk), .rst(rst), .take_i(take), .src_i(src),
    .ex_regwr_i(ex_regwr_i), .flush_o(flush_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .ex_regwr_o(ex_regwr_o)
  );

  exc_state_regs #(.XLEN(XLEN)) st_i (
    .clk(clk), .rst(rst), .take_i(take), .cause_i(cause_n), .pc_i(pc_n),
    .ack_i(ack_i), .held_o(held_o), .cause_o(cause_o), .epc_o(epc_o)
  );

  // R5: redirect comes with a squash of the fetch/decode register
  a_r5_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (flush_o[0] && redirect_pc_o == VECTOR));
  // R2: accepted overflow records cause 12
  a_r2_cause: assert property (@(posedge clk) disable iff (rst)
    (ex_ovf_i && !held_o) |=> (cause_o == 5'd12));
endmodule

// File: tb/exc_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module exc_ctrl_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] id_pc = '0, ex_pc = '0;
  logic und = 0, svc = 0, ovf = 0, rw = 0, irq = 0, hwf = 0, ack = 0;
  logic [2:0]  flush;
  logic        redir, rw_o, held;
  logic [31:0] redir_pc, epc;
  logic [4:0]  cause;

  int checks = 0, fails = 0;
  logic done = 0;
  logic        m_held = 0;
  logic [4:0]  m_cause = 0;
  logic [31:0] m_epc = 0;

  always #2.5 clk = ~clk;

  exc_ctrl_unit dut_i (
    .clk(clk), .rst(rst), .id_pc_i(id_pc), .ex_pc_i(ex_pc),
    .id_undef_i(und), .id_syscall_i(svc), .ex_ovf_i(ovf), .ex_regwr_i(rw),
    .io_irq_i(irq), .hw_err_i(hwf), .ack_i(ack), .flush_o(flush),
    .redirect_o(redir), .redirect_pc_o(redir_pc), .ex_regwr_o(rw_o),
    .cause_o(cause), .epc_o(epc), .held_o(held)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_cause();
    if (ovf) return 5'd12;
    if (hwf) return 5'd15;
    if (und) return 5'd10;
    if (svc) return 5'd8;
    return 5'd0;
  endfunction

  function automatic logic [2:0] exp_flush(logic tk);
    if (!tk) return 3'b000;
    return ovf ? 3'b111 : 3'b011;
  endfunction

  // called after inputs settle, before the edge
  task automatic step();
    logic tk;
    tk = !m_held && (ovf || hwf || und || svc || irq);
    #1;
    chk(ovf ? "R4 flush(ovf)" : "R4 flush", {29'd0, flush}, {29'd0, exp_flush(tk)});
    chk("R5 redirect", {31'd0, redir}, {31'd0, tk});
    if (tk) chk("R5 vector", redir_pc, 32'h8000_0180);
    chk("R6 regwrite gate", {31'd0, rw_o}, {31'd0, rw && !(tk && ovf)});
    if (m_held) chk("R7 masked flush", {29'd0, flush}, 32'd0);
    if (tk) begin
      m_cause = exp_cause();
      m_epc   = ovf ? ex_pc : id_pc;
      m_held  = 1'b1;
    end else if (ack) m_held = 1'b0;
    @(negedge clk);
    chk("R9/R8 held", {31'd0, held}, {31'd0, m_held});
    chk(tk && ovf ? "R2 cause" : "R3/R7 cause", {27'd0, cause}, {27'd0, m_cause});
    chk(tk && ovf ? "R2 epc" : "R3/R7 epc", epc, m_epc);
  endtask

  task automatic set_src(logic o, logic h, logic u, logic s, logic i, logic a);
    ovf = o; hwf = h; und = u; svc = s; irq = i; ack = a;
    id_pc = $urandom; ex_pc = $urandom; rw = $urandom_range(0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 cause reset", {27'd0, cause}, 32'd0);
    chk("R1 epc reset", epc, 32'd0);
    chk("R1 held reset", {31'd0, held}, 32'd0);
    // R2: all sources at once, overflow wins
    set_src(1, 1, 1, 1, 1, 0); step();
    set_src(0, 0, 0, 0, 0, 1); step();
    // R3: each decode-stage rank
    set_src(0, 1, 1, 1, 1, 0); step(); set_src(0, 0, 0, 0, 0, 1); step();
    set_src(0, 0, 1, 1, 1, 0); step(); set_src(0, 0, 0, 0, 0, 1); step();
    set_src(0, 0, 0, 1, 1, 0); step(); set_src(0, 0, 0, 0, 0, 1); step();
    set_src(0, 0, 0, 0, 1, 0); step();
    // R7: sources while held are ignored
    set_src(1, 1, 0, 0, 0, 0); step();
    // R8: request with the clear is ignored, the next one taken
    set_src(0, 0, 1, 0, 0, 1); step();
    set_src(0, 0, 0, 1, 0, 0); step();
    set_src(0, 0, 0, 0, 0, 1); step();
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      set_src($urandom_range(0, 5) == 0, $urandom_range(0, 7) == 0,
              $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
              $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0);
      step();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule